// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block guesses whether a branch at a given fetch address will be taken. It runs two predictors side by side and picks one per branch. The first is a table of 2-bit counters addressed by a 12-bit register holding the outcomes of the most recent branches, whatever their addresses. The second works in two stages. A table of 10-bit per-address outcome histories is selected by the fetch address. The chosen history then addresses a table of 3-bit counters. A third table of 2-bit counters, addressed by the shared history, learns which of the two predictors to trust.

Prediction is combinational from `pred_pc`. Along with the final direction, the block reports the choice it made, both component guesses and both history values. The fetch side keeps these with the branch and hands them back on the resolve port together with the real outcome. All training happens on resolve: the counters addressed by the returned values are updated, and the outcome is shifted into the shared history and into the per-address history of `res_pc`. The state totals 29K bits: 8K chooser, 8K shared-history counters, 10K per-address histories and 3K local counters.

Top module: `tournament_predictor`

## Requirements
- R1: After a synchronous active-low reset, every 2-bit counter holds 01 and every 3-bit counter holds 011, which is weakly not taken. The shared history and all per-address histories are zero. The first prediction is therefore not taken, comes from the local side, and reports both histories as 0.
- R2: A 2-bit counter predicts taken when its bit 1 is set. It counts up on a taken outcome and down on a not-taken one, and stays put at 11 and at 00. A single wrong outcome therefore never flips a saturated counter.
- R3: The shared history is 12 bits wide. Each resolve shifts the outcome in at bit 0 (1 = taken), with the oldest outcome leaving at bit 11. `pred_ghist` shows its current value.
- R4: The shared-history counter is addressed by the current shared history at predict time and by `res_ghist` at resolve time. Its direction appears on `pred_global_dir`.
- R5: The per-address history entry is selected by pc bits 11:2, so addresses that differ only above bit 11 share an entry. Each entry is 10 bits wide and records the outcomes of resolves whose `res_pc` selects it, newest at bit 0. `pred_lhist` shows the entry for `pred_pc`.
- R6: The 3-bit local counter is addressed by the selected per-address history at predict time and by `res_lhist` at resolve time. It predicts taken when bit 2 is set, counts toward the outcome, and stays put at 111 and at 000.
- R7: The chooser counter is addressed like the shared-history counter. When its bit 1 is set it selects the shared-history prediction. It changes only when `res_global_dir` differs from `res_local_dir`: it counts up if `res_global_dir` equals the outcome and down otherwise, saturating at both ends.
- R8: `pred_taken` equals the direction of the component named by `pred_use_global` (1 = shared-history side). When both components agree, it equals their common direction.
- R9: Resolve updates use the returned `res_ghist`, `res_lhist`, `res_global_dir` and `res_local_dir` as given. They do not use values recomputed from the current state.
- R10: Without `res_valid`, nothing held by the block changes, whatever the other resolve inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pred_pc | input | 32 | Fetch address to predict |
| pred_taken | output | 1 | Final direction, 1 = taken |
| pred_use_global | output | 1 | 1 when the shared-history side was chosen |
| pred_global_dir | output | 1 | Shared-history counter direction |
| pred_local_dir | output | 1 | Local counter direction |
| pred_ghist | output | 12 | Shared history used for this prediction |
| pred_lhist | output | 10 | Per-address history used for this prediction |
| res_valid | input | 1 | Resolve strobe, one cycle per branch |
| res_pc | input | 32 | Address of the resolved branch |
| res_taken | input | 1 | Real outcome, 1 = taken |
| res_ghist | input | 12 | Shared history captured at predict time |
| res_lhist | input | 10 | Per-address history captured at predict time |
| res_global_dir | input | 1 | Shared-history direction captured at predict time |
| res_local_dir | input | 1 | Local direction captured at predict time |

## Verification
The assertions assume that `res_valid` and every resolve field carry known values on each clock edge. They also assume that reset is held across at least one edge before training begins. The resolve fields are not assumed to match an earlier prediction. The stimulus uses this freedom: it trains chosen counters by returning fixed indices and arbitrary component guesses, and places the shared and per-address histories at chosen values by feeding streams of outcomes addressed to scratch counters. Every input is driven half a cycle away from the sampling edge, so each resolve is a single clean pulse.

// File: rtl/tp_pkg.sv
// Shared definitions for the tournament direction predictor.
// Assumes instruction addresses are 4-byte aligned, so the low pc bits carry no index.
package tp_pkg;
    localparam int PC_LSB = 2;

    // Which component the chooser picked.
    typedef enum logic {
        SRC_LOCAL  = 1'b0,
        SRC_GLOBAL = 1'b1
    } src_e;
endpackage

// File: rtl/tp_sat_table.sv
// Table of saturating counters with one combinational read port and one update port.
// Read returns the counter MSB (its direction). Update moves the addressed counter one step
// up or down and stops at the ends. Reset loads weakly-not-taken (MSB 0, other bits 1).
// Assumes wr_idx and wr_up are stable and known when wr_en is high.
module tp_sat_table #(
    parameter int IDX_W = 12,
    parameter int CTR_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_dir,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_up
);
    localparam int               DEPTH    = 1 << IDX_W;
    localparam logic [CTR_W-1:0] CTR_MAX  = '1;
    localparam logic [CTR_W-1:0] CTR_INIT = CTR_MAX >> 1;

    logic [CTR_W-1:0] mem [DEPTH];
    logic [CTR_W-1:0] cur;
    logic [CTR_W-1:0] nxt;

    // Direction of the counter being read.
    assign rd_dir = mem[rd_idx][CTR_W-1];

    // Next value of the counter being updated, saturating at both ends.
    always_comb begin
        cur = mem[wr_idx];
        if (wr_up) nxt = (cur == CTR_MAX) ? cur : cur + CTR_W'(1);
        else       nxt = (cur == '0)      ? cur : cur - CTR_W'(1);
    end

    // Counter storage with reset to weakly not taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
        end else if (wr_en) begin
            mem[wr_idx] <= nxt;
        end
    end

    AST_CTR_HOLD_MAX: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_up && mem[wr_idx] == CTR_MAX) |=> (mem[$past(wr_idx)] == CTR_MAX)); // R2
    AST_CTR_HOLD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_up && mem[wr_idx] == '0) |=> (mem[$past(wr_idx)] == '0)); // R6
endmodule

// File: rtl/tp_hist_table.sv
// Table of per-address outcome histories. Read is combinational. An update shifts one
// outcome into bit 0 of the addressed entry. Reset clears every entry.
// Assumes wr_idx and wr_bit are known when wr_en is high.
module tp_hist_table #(
    parameter int IDX_W  = 10,
    parameter int HIST_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [HIST_W-1:0] rd_hist,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic              wr_bit
);
    localparam int DEPTH = 1 << IDX_W;

    logic [HIST_W-1:0] tab [DEPTH];

    // History of the entry being read.
    assign rd_hist = tab[rd_idx];

    // History storage: shift the newest outcome in at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) tab[i] <= '0;
        end else if (wr_en) begin
            tab[wr_idx] <= {tab[wr_idx][HIST_W-2:0], wr_bit};
        end
    end

    AST_LHIST_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (tab[$past(wr_idx)][0] == $past(wr_bit))); // R5
endmodule

// File: rtl/tournament_predictor.sv
// Tournament branch direction predictor.
// A shared-history counter table and a two-level local predictor each give a direction.
// A chooser table, addressed by the shared history, picks one. Prediction is combinational
// from pred_pc. Training happens on resolve using the indices and component directions
// returned from predict time.
// Assumes one resolve per cycle at most and 4-byte aligned addresses.
module tournament_predictor #(
    parameter int PC_W     = 32,
    parameter int GH_W     = 12,
    parameter int LH_W     = 10,
    parameter int LT_IDX_W = 10,
    parameter int GCTR_W   = 2,
    parameter int LCTR_W   = 3,
    parameter int CH_W     = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    output logic            pred_use_global,
    output logic            pred_global_dir,
    output logic            pred_local_dir,
    output logic [GH_W-1:0] pred_ghist,
    output logic [LH_W-1:0] pred_lhist,
    input  logic            res_valid,
    input  logic [PC_W-1:0] res_pc,
    input  logic            res_taken,
    input  logic [GH_W-1:0] res_ghist,
    input  logic [LH_W-1:0] res_lhist,
    input  logic            res_global_dir,
    input  logic            res_local_dir
);
    import tp_pkg::*;

    localparam int LIDX_LO = PC_LSB;
    localparam int LIDX_HI = PC_LSB + LT_IDX_W - 1;

    logic [GH_W-1:0]     ghr;
    logic [LT_IDX_W-1:0] pred_lt_idx;
    logic [LT_IDX_W-1:0] res_lt_idx;
    logic                g_dir;
    logic                l_dir;
    logic                choose_msb;
    src_e                chosen;
    logic                chooser_upd;
    logic                unused_pc_bits;

    assign pred_lt_idx    = pred_pc[LIDX_HI:LIDX_LO];
    assign res_lt_idx     = res_pc[LIDX_HI:LIDX_LO];
    assign unused_pc_bits = ^{pred_pc[PC_W-1:LIDX_HI+1], pred_pc[LIDX_LO-1:0],
                              res_pc[PC_W-1:LIDX_HI+1], res_pc[LIDX_LO-1:0]};

    // Shared outcome history, newest outcome at bit 0.
    always_ff @(posedge clk) begin
        if (!rst_n)         ghr <= '0;
        else if (res_valid) ghr <= {ghr[GH_W-2:0], res_taken};
    end

    // Shared-history counters.
    tp_sat_table #(.IDX_W(GH_W), .CTR_W(GCTR_W)) u_gtab (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghr), .rd_dir(g_dir),
        .wr_en(res_valid), .wr_idx(res_ghist), .wr_up(res_taken)
    );

    // First local stage: per-address histories.
    tp_hist_table #(.IDX_W(LT_IDX_W), .HIST_W(LH_W)) u_lhist (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_lt_idx), .rd_hist(pred_lhist),
        .wr_en(res_valid), .wr_idx(res_lt_idx), .wr_bit(res_taken)
    );

    // Second local stage: counters addressed by the local history.
    tp_sat_table #(.IDX_W(LH_W), .CTR_W(LCTR_W)) u_ltab (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(pred_lhist), .rd_dir(l_dir),
        .wr_en(res_valid), .wr_idx(res_lhist), .wr_up(res_taken)
    );

    // Chooser: trained only when the returned component guesses differ.
    assign chooser_upd = res_valid && (res_global_dir != res_local_dir);

    tp_sat_table #(.IDX_W(GH_W), .CTR_W(CH_W)) u_choose (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(ghr), .rd_dir(choose_msb),
        .wr_en(chooser_upd), .wr_idx(res_ghist), .wr_up(res_global_dir == res_taken)
    );

    // Final selection and reported prediction fields.
    always_comb begin
        chosen          = src_e'(choose_msb);
        pred_use_global = (chosen == SRC_GLOBAL);
        pred_taken      = (chosen == SRC_GLOBAL) ? g_dir : l_dir;
        pred_global_dir = g_dir;
        pred_local_dir  = l_dir;
        pred_ghist      = ghr;
    end

    // Agreement check on the final direction.
    always_comb begin
        if (rst_n && (g_dir == l_dir)) begin
            AST_AGREE_PASS: assert (pred_taken == g_dir); // R8
        end
    end

    AST_GHR_NEWEST: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> (ghr[0] == $past(res_taken))); // R3
    AST_GHR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |=> $stable(ghr)); // R10
endmodule

// File: tb/sim_tournament_predictor.sv
`timescale 1ns/1ps
module sim_tournament_predictor;
    localparam real CLK_HALF = 2.5;

    localparam logic [31:0] P      = 32'h0000_0100;
    localparam logic [31:0] P2     = 32'h0000_0300;
    localparam logic [31:0] SCR_PC = 32'h0000_0800;
    localparam logic [11:0] G      = 12'h0F0;
    localparam logic [11:0] G2     = 12'h00F;
    localparam logic [11:0] SCR_G  = 12'h555;
    localparam logic [9:0]  L      = 10'h2A5;
    localparam logic [9:0]  L2     = 10'h0C3;
    localparam logic [9:0]  SCR_L  = 10'h155;

    // Vector bits: [5] kind, [4] outcome, [3] gdir in, [2] ldir in, [1] exp A, [0] exp B.
    // kind 0: train counters at G / L, expect A = global dir, B = local dir.
    // kind 1: train chooser at G2 with given guesses, expect A = use_global, B = final taken.
    localparam int NV = 28;
    localparam logic [5:0] VEC [NV] = '{
        6'b0_1_00_11, 6'b0_1_00_11, 6'b0_1_00_11, 6'b0_1_00_11, 6'b0_1_00_11,
        6'b0_0_00_11, 6'b0_0_00_01, 6'b0_0_00_01, 6'b0_0_00_00, 6'b0_0_00_00,
        6'b0_0_00_00, 6'b0_0_00_00, 6'b0_0_00_00, 6'b0_1_00_00, 6'b0_1_00_10,
        6'b0_1_00_10, 6'b0_1_00_11,
        6'b1_1_10_11, 6'b1_1_10_11, 6'b1_1_10_11, 6'b1_0_11_11, 6'b1_1_01_11,
        6'b1_1_01_00, 6'b1_0_10_00, 6'b1_0_10_00, 6'b1_1_00_00, 6'b1_0_01_00,
        6'b1_1_10_11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        pred_taken, pred_use_global, pred_global_dir, pred_local_dir;
    logic [11:0] pred_ghist;
    logic [9:0]  pred_lhist;
    logic        res_valid = 1'b0;
    logic [31:0] res_pc = '0;
    logic        res_taken = 1'b0;
    logic [11:0] res_ghist = '0;
    logic [9:0]  res_lhist = '0;
    logic        res_global_dir = 1'b0;
    logic        res_local_dir = 1'b0;

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #(CLK_HALF) clk = ~clk;

    tournament_predictor u0 (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc),
        .pred_taken(pred_taken), .pred_use_global(pred_use_global),
        .pred_global_dir(pred_global_dir), .pred_local_dir(pred_local_dir),
        .pred_ghist(pred_ghist), .pred_lhist(pred_lhist),
        .res_valid(res_valid), .res_pc(res_pc), .res_taken(res_taken),
        .res_ghist(res_ghist), .res_lhist(res_lhist),
        .res_global_dir(res_global_dir), .res_local_dir(res_local_dir)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // One resolve pulse; called and returns at a falling edge.
    task automatic do_res(input logic [31:0] pc, input logic t, input logic [11:0] g,
                          input logic [9:0] l, input logic gd, input logic ld);
        res_valid = 1'b1; res_pc = pc; res_taken = t; res_ghist = g;
        res_lhist = l; res_global_dir = gd; res_local_dir = ld;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    // Place the shared history at v by streaming outcomes at scratch counters.
    task automatic set_ghr(input logic [11:0] v);
        for (int i = 11; i >= 0; i--) do_res(SCR_PC, v[i], SCR_G, SCR_L, 1'b0, 1'b0);
    endtask

    // Place the per-address history of pc at v.
    task automatic set_lhist(input logic [31:0] pc, input logic [9:0] v);
        for (int i = 9; i >= 0; i--) do_res(pc, v[i], SCR_G, SCR_L, 1'b0, 1'b0);
    endtask

    task automatic look(input logic [31:0] pc);
        pred_pc = pc;
        #1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state as seen at the predict port.
        look(P);
        chk("R1 taken", {31'b0, pred_taken}, 32'd0);
        chk("R1 use_global", {31'b0, pred_use_global}, 32'd0);
        chk("R1 ghist", {20'b0, pred_ghist}, 32'd0);
        chk("R1 lhist", {22'b0, pred_lhist}, 32'd0);
        chk("R1 gdir", {31'b0, pred_global_dir}, 32'd0);

        set_lhist(P, L);
        set_lhist(P2, L2);
        look(P);
        chk("R5 lhist set", {22'b0, pred_lhist}, {22'b0, L});

        // Table walk: counter saturation (R2 R4 R6) and chooser training (R7 R8 R9).
        for (int i = 0; i < NV; i++) begin
            if (!VEC[i][5]) begin
                do_res(SCR_PC, VEC[i][4], G, L, 1'b0, 1'b0);
                set_ghr(G);
                look(P);
                chk($sformatf("R2 R4 vec %0d gdir", i), {31'b0, pred_global_dir}, {31'b0, VEC[i][1]});
                chk($sformatf("R6 vec %0d ldir", i), {31'b0, pred_local_dir}, {31'b0, VEC[i][0]});
            end else begin
                do_res(SCR_PC, VEC[i][4], G2, SCR_L, VEC[i][3], VEC[i][2]);
                set_ghr(G2);
                look(P2);
                chk($sformatf("R7 R9 vec %0d use_global", i), {31'b0, pred_use_global}, {31'b0, VEC[i][1]});
                chk($sformatf("R8 vec %0d taken", i), {31'b0, pred_taken}, {31'b0, VEC[i][0]});
            end
        end

        // R3 R5: reported histories and address aliasing above bit 11.
        set_ghr(G);
        look(P);
        chk("R3 ghist", {20'b0, pred_ghist}, {20'b0, G});
        chk("R5 lhist", {22'b0, pred_lhist}, {22'b0, L});
        look(P + 32'h1000);
        chk("R5 alias lhist", {22'b0, pred_lhist}, {22'b0, L});
        look(P + 32'h4);
        chk("R5 neighbour lhist", {22'b0, pred_lhist}, 32'd0);

        // R10: junk on resolve fields without res_valid changes nothing.
        res_pc = P; res_taken = 1'b0; res_ghist = G; res_lhist = L;
        res_global_dir = 1'b1; res_local_dir = 1'b0;
        repeat (6) @(negedge clk);
        look(P);
        chk("R10 ghist", {20'b0, pred_ghist}, {20'b0, G});
        chk("R10 lhist", {22'b0, pred_lhist}, {22'b0, L});
        chk("R10 gdir", {31'b0, pred_global_dir}, 32'd1);

        // R1: reset again clears trained state.
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        look(P);
        chk("R1 re ghist", {20'b0, pred_ghist}, 32'd0);
        chk("R1 re lhist", {22'b0, pred_lhist}, 32'd0);
        chk("R1 re taken", {31'b0, pred_taken}, 32'd0);

        // R3: newest outcome enters at bit 0.
        do_res(SCR_PC, 1'b1, SCR_G, SCR_L, 1'b0, 1'b0);
        look(P);
        chk("R3 shift one", {20'b0, pred_ghist}, 32'h001);
        do_res(SCR_PC, 1'b0, SCR_G, SCR_L, 1'b0, 1'b0);
        look(P);
        chk("R3 shift two", {20'b0, pred_ghist}, 32'h002);
        set_ghr(G);
        look(P);
        chk("R1 re gdir at G", {31'b0, pred_global_dir}, 32'd0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        #(CLK_HALF * 2.0 * 100000.0);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule